// File: doc/BRIEF.md
# Enable-gated modulo counter with terminal flag

This block counts clock edges from zero up to a fixed terminal value and then returns to zero. This gives a cycle of `TERM_VAL + 1` states. Each bit position has its own next-state action: hold, toggle or clear. A bit is told to toggle when every lower bit is one. A decoder watches the full state word. When that word is the terminal value, or lies outside the legal range, every bit is told to clear instead of toggle.

Counting happens only on clock edges where `count_en` is high. On every other edge the contents stay frozen. A terminal flag shows that the state equals the terminal value, whatever `count_en` is doing. A user can therefore pause the counter on its last step and still see that the cycle is complete. A synchronous active-low clear puts the register at zero, so it never starts in an unused value.

The defaults are three bits and a terminal value of 5, which gives a modulo-6 counter.

Top module: `modn_counter`

## Requirements
- R1: On a clock edge with `rst_n` high and `count_en` high, and with the state below `TERM_VAL`, the state advances by exactly one.
- R2: On a clock edge with `rst_n` high and `count_en` low, the state keeps its value.
- R3: `term_hit` is high in exactly the cycles where `state_q` equals `TERM_VAL`, independent of `count_en`.
- R4: When the state equals `TERM_VAL` and `count_en` is high, the next state is 0. A full cycle therefore takes `TERM_VAL + 1` counting edges.
- R5: The state never exceeds `TERM_VAL`. Any value above it is forced to 0 on the next counting edge.
- R6: `rst_n` low at a clock edge sets the state to 0, and this overrides `count_en`.
- R7: When the state equals `TERM_VAL` and `count_en` is low, the counter stays at `TERM_VAL` and `term_hit` stays high.
- R8: With the default parameters (3 bits, `TERM_VAL` = 5), counting edges visit 0,1,2,3,4,5,0 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear to zero |
| count_en | input | 1 | High: advance on this edge; low: hold |
| state_q | output | CNT_W | Present count value |
| term_hit | output | 1 | High while `state_q` equals `TERM_VAL` |

## Verification
Two pairs of functions can fall in the same cycle:
- **Terminal wrap and freeze.** The state reaches `TERM_VAL` while `count_en` is low. The bench holds it there for several edges and expects the value to stay and the flag to stay high. It then raises `count_en` for a single edge and expects 0.
- **Clear and wrap.** `rst_n` is pulled low exactly when the counter sits at the terminal value with `count_en` high. Both the clear and the wrap would give zero, so the bench repeats the clear at a mid-range value to show that the clear wins.

An enable pattern with gaps is compared against a reference model, and the bench judges every edge against that model.

// File: rtl/modn_pkg.sv
// Shared types for the modulo counter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package modn_pkg;
    // Next-state action for one bit of the counter.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2
    } stage_act_e;
endpackage

// File: rtl/modn_term_decode.sv
// Terminal-word decoder: builds the minterm of TERM_VAL from the state
// bits, and flags any state word above TERM_VAL as out of range.
// Assumes: TERM_VAL fits in CNT_W bits.
module modn_term_decode #(
    parameter int CNT_W    = 3,
    parameter int TERM_VAL = 5
) (
    input  logic [CNT_W-1:0] state,
    output logic             term_hit,
    output logic             over_hit
);
    localparam logic [CNT_W-1:0] TERM_BITS = CNT_W'(TERM_VAL);

    logic [CNT_W-1:0] lit;

    // One literal per bit: the true bit where the terminal value has a 1,
    // the inverted bit where it has a 0.
    for (genvar g = 0; g < CNT_W; g++) begin : g_lit
        if (TERM_BITS[g]) begin : g_true
            assign lit[g] = state[g];
        end else begin : g_comp
            assign lit[g] = ~state[g];
        end
    end

    // The minterm is the AND of all literals; out of range is a magnitude compare.
    always_comb begin
        term_hit = &lit;
        over_hit = (state > TERM_BITS);
    end
endmodule

// File: rtl/modn_toggle_bit.sv
// One counter bit that can hold, toggle or clear on each edge.
// Assumes: the action is settled before the rising edge; rst_n is synchronous.
module modn_toggle_bit
    import modn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_act_e act,
    output logic       q
);
    // Bit register: the clear wins, then the requested action is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (act)
                ACT_TOGGLE: q <= ~q;
                ACT_CLEAR:  q <= 1'b0;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/modn_counter.sv
// Modulo (TERM_VAL+1) synchronous up counter with count enable.
// Bit i toggles when every lower bit is one. When the state is at or above
// TERM_VAL, every bit is told to clear instead. With count_en low, every
// bit holds.
// Assumes: 1 <= TERM_VAL < 2**CNT_W; rst_n is synchronous and active low.
module modn_counter
    import modn_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int TERM_VAL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    output logic [CNT_W-1:0] state_q,
    output logic             term_hit
);
    localparam logic [CNT_W-1:0] TERM_BITS = CNT_W'(TERM_VAL);

    logic             dec_term;
    logic             dec_over;
    logic             wrap;
    logic [CNT_W-1:0] carry;
    stage_act_e       act [CNT_W];

    // Terminal and out-of-range detection on the full state word.
    modn_term_decode #(
        .CNT_W   (CNT_W),
        .TERM_VAL(TERM_VAL)
    ) u_dec (
        .state   (state_q),
        .term_hit(dec_term),
        .over_hit(dec_over)
    );

    // The forced clear applies at the terminal word and above it.
    assign wrap     = dec_term | dec_over;
    assign term_hit = dec_term;

    // Toggle chain: bit 0 always wants to toggle; each higher bit wants to
    // toggle only when every lower bit is one.
    assign carry[0] = 1'b1;
    for (genvar g = 1; g < CNT_W; g++) begin : g_carry
        assign carry[g] = carry[g-1] & state_q[g-1];
    end

    // Per-bit action and register.
    for (genvar g = 0; g < CNT_W; g++) begin : g_bit
        assign act[g] = !count_en ? ACT_HOLD   :
                        wrap      ? ACT_CLEAR  :
                        carry[g]  ? ACT_TOGGLE : ACT_HOLD;

        modn_toggle_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .act  (act[g]),
            .q    (state_q[g])
        );
    end

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> state_q == '0);

    // R1
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && state_q < TERM_BITS) |=> state_q == $past(state_q) + CNT_W'(1));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> $stable(state_q));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && term_hit) |=> state_q == '0);

    // R5
    no_overrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= TERM_BITS);

    // R7
    term_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && term_hit) |=> term_hit);
endmodule

// File: tb/tb_modn_counter.sv
// Directed bench for modn_counter. Inputs change 2 ns after a rising
// edge and outputs are sampled there.
module tb_modn_counter;
    localparam int W    = 3;
    localparam int TERM = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         count_en = 1'b0;
    logic [W-1:0] state_q;
    logic         term_hit;
    int           n_chk = 0;
    int           n_fail = 0;
    int           model = 0;

    modn_counter #(.CNT_W(W), .TERM_VAL(TERM)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(count_en),
        .state_q (state_q),
        .term_hit(term_hit)
    );

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    // Compare one value against its expectation and count the check.
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs for one edge, advance the reference model, then sample.
    task automatic step(input logic en, input logic rv);
        count_en = en;
        rst_n    = rv;
        @(posedge clk);
        #2;
        if (!rv) model = 0;
        else if (en) model = (model == TERM) ? 0 : model + 1;
    endtask

    // R6: the clear gives zero even with count_en high.
    task automatic t_reset;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R6 reset state", int'(state_q), 0);
        chk("R3 flag low after reset", int'(term_hit), 0);
    endtask

    // R1/R4/R8/R3/R5: free count across two full cycles.
    task automatic t_sequence;
        for (int i = 0; i < 13; i++) begin
            step(1'b1, 1'b1);
            chk("R8 R1 R4 sequence", int'(state_q), model);
            chk("R3 flag", int'(term_hit), int'(model == TERM));
            chk("R5 range", int'(state_q <= TERM), 1);
        end
    endtask

    // R2: freeze at a mid value.
    task automatic t_hold;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1);
            chk("R2 hold", int'(state_q), 2);
        end
    endtask

    // R7/R3/R4: park on the terminal value, then release one edge.
    task automatic t_term_freeze;
        while (model != TERM) step(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1);
            chk("R7 parked value", int'(state_q), TERM);
            chk("R3 flag with count low", int'(term_hit), 1);
        end
        step(1'b1, 1'b1);
        chk("R4 wrap after release", int'(state_q), 0);
        chk("R3 flag drops", int'(term_hit), 0);
    endtask

    // R6: clear coinciding with the terminal value, then with a mid value.
    task automatic t_reset_collide;
        while (model != TERM) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R6 clear at terminal", int'(state_q), 0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R6 clear mid count", int'(state_q), 0);
    endtask

    // R5/R1/R2: enable pattern with gaps against the model.
    task automatic t_gapped;
        for (int i = 0; i < 40; i++) begin
            step(((i * 7) % 5) < 3, 1'b1);
            chk("R5 R1 R2 gapped", int'(state_q), model);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Test sequence.
    initial begin
        t_reset;
        t_sequence;
        t_hold;
        t_term_freeze;
        t_reset_collide;
        t_gapped;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule